// File: doc/BRIEF.md
# Colour Standard Search Sequencer

This block is the control sequencer of a video decoder's colour-standard recognition. It walks a programmable list of eight candidate standard codes. For each candidate it runs a trial of two field periods and samples a pass/fail verdict from an external detector. A candidate code of `110` or `111` ends the walk early. When the walk ends, the block counts how many trials passed. If exactly one trial passed, it enters a confirmation phase on that candidate. If none passed, or more than one passed, it starts the walk again from the first list slot.

During confirmation the detector must report a pass on a programmable number of consecutive fields. When that count is reached, the block raises its identified flag and publishes the 3-bit code. A single failing field during confirmation sends the sequencer back to the first list slot.

The detector itself sits outside the block. It watches `trial_code` to learn which standard to test, and answers on `trial_match` together with each `field_stb`. Standard codes are: `000` PAL B/D/G/H/I, `001` SECAM, `010` NTSC M, `011` PAL M, `100` PAL N, `101` NTSC 4.43, and `110`/`111` no standard.

Top module: `ssq_std_search`

The sequencer has four states:

- `S_TRIAL` runs trials on successive list slots.
- `S_DECIDE` lasts one cycle and judges the pass count.
- `S_CONFIRM` counts consecutive good fields.
- `S_LOCKED` holds the result.

It has these transitions:

- `S_TRIAL`→`S_DECIDE` when the current slot holds a terminator code, or when the trial on slot 7 completes.
- `S_DECIDE`→`S_CONFIRM` when exactly one trial passed.
- `S_DECIDE`→`S_TRIAL` (slot 0) otherwise.
- `S_CONFIRM`→`S_LOCKED` on the last required good field.
- `S_CONFIRM`→`S_TRIAL` (slot 0) on a bad field.
- Any state →`S_TRIAL` (slot 0) on `restart`.

## Requirements
- R1: After reset the sequencer is in `S_TRIAL` at slot 0: `std_found` is 0, `std_code` is `111`, and `trial_code` equals the code in slot 0.
- R2: Slots are tried in ascending order; slot i's code is at `tbl_flat[3*i+2:3*i]`. Each trial spans two `field_stb` pulses, and `trial_match` is sampled only on the second pulse. `trial_code` shows the slot under trial.
- R3: A slot code of `110` or `111` ends the walk; it and all later slots are not tried. After slot 7's trial the walk also ends.
- R4: If exactly one trial passed, the sequencer enters `S_CONFIRM` and `trial_code` shows that slot's code. This holds no later than three clock cycles after the last trial strobe.
- R5: If zero trials passed, or two or more passed (even with identical codes), nothing is identified and the walk restarts at slot 0.
- R6: Confirmation needs this many consecutive good fields: code `000`→1, `001`→3, `010`→7, `011`→10, and `100`–`111`→10. `std_found` rises in the cycle after the strobe that completes the count, never earlier.
- R7: A field strobe with `trial_match` low during confirmation returns the sequencer to `S_TRIAL` at slot 0 without identification.
- R8: While identified, `std_found` is 1 and `std_code` holds the confirmed code, which never changes until restart. While not identified, `std_code` reads `111`.
- R9: A synchronous `restart` pulse clears `std_found` in the next cycle and restarts the walk at slot 0. It takes priority over every other event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart of the search |
| field_stb | input | 1 | One-cycle pulse per field |
| trial_match | input | 1 | Detector verdict, valid with `field_stb` |
| tbl_flat | input | 24 | Eight 3-bit candidate codes, slot 0 in the low bits |
| confirm_code | input | 3 | Confirmation length selector |
| trial_code | output | 3 | Code under trial or confirmation (`111` while deciding) |
| std_found | output | 1 | Standard identified |
| std_code | output | 3 | Identified code, `111` when none |

## Verification
The hardest situations to reach are the ambiguous result and the confirmation failure. In both, the outputs look like an idle search unless the candidate code differs from slot 0's code.

The stimulus therefore builds tables in which the would-be candidate differs from slot 0. One table repeats the same code in two passing slots, so only the restart shows the ambiguity. Another sets a matching slot just past a terminator, so a walk that ignored the terminator would pick a different candidate.

The confirmation lengths are probed one field short of the target and then exactly at it.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
    localparam int CODE_W   = 3;
    localparam int CONF_W   = 4;
    localparam logic [CODE_W-1:0] NO_STD = 3'b111;

    typedef enum logic [1:0] {
        S_TRIAL,
        S_DECIDE,
        S_CONFIRM,
        S_LOCKED
    } ssq_state_e;

    // Number of consecutive good fields demanded by a confirmation code.
    function automatic logic [CONF_W-1:0] conf_fields(input logic [2:0] c);
        case (c)
            3'd0:    conf_fields = 4'd1;
            3'd1:    conf_fields = 4'd3;
            3'd2:    conf_fields = 4'd7;
            default: conf_fields = 4'd10;
        endcase
    endfunction
endpackage

// File: rtl/ssq_entry_sel.sv
module ssq_entry_sel
    import ssq_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT*CODE_W-1:0] tbl_flat,
    input  logic [IDX_W-1:0]        idx,
    output logic [CODE_W-1:0]       code,
    output logic                    term
);
    logic [CODE_W-1:0] slot [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        assign slot[g] = tbl_flat[g*CODE_W +: CODE_W];
    end

    assign code = slot[idx];
    // Codes 110 and 111 carry no standard and end the walk.
    assign term = code[2] & code[1];
endmodule

// File: rtl/ssq_confirm_cnt.sv
module ssq_confirm_cnt
    import ssq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [CONF_W-1:0] need,
    output logic              last
);
    logic [CONF_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (step)  cnt <= cnt + CONF_W'(1);
    end

    // The good field arriving now is the final one required.
    assign last = (cnt == need - CONF_W'(1));
endmodule

// File: rtl/ssq_std_search.sv
module ssq_std_search
    import ssq_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT),
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENT - 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    field_stb,
    input  logic                    trial_match,
    input  logic [N_ENT*CODE_W-1:0] tbl_flat,
    input  logic [2:0]              confirm_code,
    output logic [CODE_W-1:0]       trial_code,
    output logic                    std_found,
    output logic [CODE_W-1:0]       std_code
);
    ssq_state_e        state, nxt_state;
    logic [IDX_W-1:0]  idx, nxt_idx;
    logic              half, nxt_half;
    logic [1:0]        hits, nxt_hits;
    logic [CODE_W-1:0] cand, nxt_cand;

    logic [CODE_W-1:0] ent_code;
    logic              ent_term;
    logic              cnt_last;

    ssq_entry_sel #(.N_ENT(N_ENT)) u_sel (
        .tbl_flat (tbl_flat),
        .idx      (idx),
        .code     (ent_code),
        .term     (ent_term)
    );

    ssq_confirm_cnt u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart || (state != S_CONFIRM)),
        .step  ((state == S_CONFIRM) && field_stb && trial_match),
        .need  (conf_fields(confirm_code)),
        .last  (cnt_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_TRIAL;
            idx   <= '0;
            half  <= 1'b0;
            hits  <= 2'd0;
            cand  <= NO_STD;
        end else begin
            state <= nxt_state;
            idx   <= nxt_idx;
            half  <= nxt_half;
            hits  <= nxt_hits;
            cand  <= nxt_cand;
        end
    end

    // Next-state logic
    always_comb begin
        nxt_state = state;
        nxt_idx   = idx;
        nxt_half  = half;
        nxt_hits  = hits;
        nxt_cand  = cand;
        if (restart) begin
            nxt_state = S_TRIAL;
            nxt_idx   = '0;
            nxt_half  = 1'b0;
            nxt_hits  = 2'd0;
        end else begin
            unique case (state)
                S_TRIAL: begin
                    if (ent_term) begin
                        nxt_state = S_DECIDE;
                    end else if (field_stb) begin
                        if (!half) begin
                            nxt_half = 1'b1;
                        end else begin
                            nxt_half = 1'b0;
                            if (trial_match) begin
                                nxt_cand = ent_code;
                                nxt_hits = (hits == 2'd2) ? 2'd2 : hits + 2'd1;
                            end
                            if (idx == LAST_IDX) nxt_state = S_DECIDE;
                            else                 nxt_idx   = idx + IDX_W'(1);
                        end
                    end
                end
                S_DECIDE: begin
                    nxt_idx   = '0;
                    nxt_half  = 1'b0;
                    nxt_hits  = 2'd0;
                    nxt_state = (hits == 2'd1) ? S_CONFIRM : S_TRIAL;
                end
                S_CONFIRM: begin
                    if (field_stb) begin
                        if (!trial_match) nxt_state = S_TRIAL;
                        else if (cnt_last) nxt_state = S_LOCKED;
                    end
                end
                S_LOCKED: begin
                    nxt_state = S_LOCKED;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            S_TRIAL:   trial_code = ent_code;
            S_DECIDE:  trial_code = NO_STD;
            S_CONFIRM: trial_code = cand;
            S_LOCKED:  trial_code = cand;
        endcase
        std_found = (state == S_LOCKED);
        std_code  = std_found ? cand : NO_STD;
    end
endmodule

// File: rtl/ssq_checker.sv
module ssq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       restart,
    input logic       field_stb,
    input logic       trial_match,
    input logic       std_found,
    input logic [2:0] std_code
);
    // R8: no code is published while nothing is identified
    a_r8_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        !std_found |-> (std_code == 3'b111));

    // R8: a published code is a real standard
    a_r8_real_code: assert property (@(posedge clk) disable iff (!rst_n)
        std_found |-> !(std_code[2] && std_code[1]));

    // R6: the flag rises only after a good field strobe
    a_r6_rise_after_field: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(std_found) |-> ($past(field_stb) && $past(trial_match)));

    // R9: restart clears the flag in the next cycle
    a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !std_found);

    // R8: an identified result holds until restart
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (std_found && !restart) |=> (std_found && $stable(std_code)));
endmodule

bind ssq_std_search ssq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .field_stb   (field_stb),
    .trial_match (trial_match),
    .std_found   (std_found),
    .std_code    (std_code)
);

// File: tb/sim_ssq_std_search.sv
module sim_ssq_std_search;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] DEF_TBL =
        {3'd7, 3'd7, 3'd1, 3'd1, 3'd7, 3'd2, 3'd1, 3'd0};
    localparam int NVEC = 9;
    // {table, confirm code, per-slot match mask}
    localparam logic [34:0] VEC [NVEC] = '{
        {DEF_TBL, 3'd1, 8'b0000_0010},
        {DEF_TBL, 3'd1, 8'b0000_0101},
        {{3'd4, 3'd5, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5}, 3'd0, 8'b0100_0000},
        {{3'd0, 3'd0, 3'd0, 3'd0, 3'd6, 3'd3, 3'd3, 3'd1}, 3'd1, 8'b0000_0110},
        {{3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd6, 3'd4}, 3'd2, 8'b0000_0001},
        {{3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd7, 3'd3}, 3'd3, 8'b0000_0001},
        {{3'd0, 3'd7, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}, 3'd7, 8'b0010_0000},
        {DEF_TBL, 3'd1, 8'b0000_0000},
        {{3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd1, 3'd6, 3'd2}, 3'd0, 8'b0000_0101}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        field_stb = 1'b0;
    logic        trial_match = 1'b0;
    logic [23:0] tbl_flat = DEF_TBL;
    logic [2:0]  confirm_code = 3'd1;
    logic [2:0]  trial_code;
    logic        std_found;
    logic [2:0]  std_code;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssq_std_search u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (restart),
        .field_stb    (field_stb),
        .trial_match  (trial_match),
        .tbl_flat     (tbl_flat),
        .confirm_code (confirm_code),
        .trial_code   (trial_code),
        .std_found    (std_found),
        .std_code     (std_code)
    );

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic field(input logic m);
        @(negedge clk);
        field_stb   = 1'b1;
        trial_match = m;
        @(negedge clk);
        field_stb   = 1'b0;
        trial_match = 1'b0;
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    function automatic int need_of(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 3;
            3'd2: return 7;
            default: return 10;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run completion)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 flag", {2'b0, std_found}, 3'd0);
        chk("R1 code", std_code, 3'b111);
        chk("R1 slot0", trial_code, 3'd0);

        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] code0, cand;
            int hits, need;
            tbl_flat     = VEC[v][34:11];
            confirm_code = VEC[v][10:8];
            do_restart();
            hits = 0;
            cand = 3'b111;
            code0 = tbl_flat[2:0];
            for (int i = 0; i < 8; i++) begin
                logic [2:0] c;
                c = tbl_flat[3*i +: 3];
                if (c[2] && c[1]) break;   // R3: terminator ends the walk
                chk("R2 slot order", trial_code, c);
                field(1'b0);
                field(VEC[v][i]);
                if (VEC[v][i]) begin
                    hits++;
                    cand = c;
                end
            end
            repeat (3) @(negedge clk);
            need = need_of(confirm_code);
            if (hits == 1) begin
                chk("R4 candidate", trial_code, cand);
                for (int k = 0; k < need - 1; k++) field(1'b1);
                chk("R6 early flag", {2'b0, std_found}, 3'd0);
                field(1'b1);
                chk("R6 flag", {2'b0, std_found}, 3'd1);
                chk("R8 code", std_code, cand);
            end else begin
                chk("R5 restart slot0", trial_code, code0);
                for (int k = 0; k < need; k++) field(1'b0);
                chk("R5 no flag", {2'b0, std_found}, 3'd0);
            end
        end

        // R9: restart clears a locked result
        chk("R8 still locked", {2'b0, std_found}, 3'd1);
        do_restart();
        chk("R9 flag cleared", {2'b0, std_found}, 3'd0);
        chk("R9 slot0", trial_code, tbl_flat[2:0]);

        // R7: failed field during confirmation
        tbl_flat     = DEF_TBL;
        confirm_code = 3'd1;
        do_restart();
        field(1'b0); field(1'b0);
        field(1'b0); field(1'b1);
        field(1'b0); field(1'b0);
        repeat (3) @(negedge clk);
        chk("R4 secam candidate", trial_code, 3'd1);
        field(1'b1);
        field(1'b0);
        chk("R7 back to slot0", trial_code, 3'd0);
        field(1'b1); field(1'b1); field(1'b1);
        chk("R7 no flag", {2'b0, std_found}, 3'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule